// File: doc/BRIEF.md
# Per-Select SPI Serial Clock Generator

This block produces the serial clock for an SPI master that addresses up to four peripherals. The clock comes from one of two sources: the system clock itself, or the system clock slowed by a fixed prescaler of 32. A per-peripheral 8-bit divisor then divides the chosen source. The block holds one divisor input for each peripheral select and picks the right one by the active select index when a transfer starts. The serial rate therefore follows the addressed peripheral without any reprogramming between transfers.

A transfer runs for as long as `run_i` is held high. The source choice, the select index and the divisor are captured in the cycle the transfer starts, and later changes to them are ignored until the next start. The clock follows SPI mode 0: it idles low and begins each transfer with a low phase. A one-cycle `capture_o` strobe marks each rising edge, where the receiver samples. A one-cycle `launch_o` strobe marks each falling edge, where the transmitter shifts. A zero divisor is illegal. A start attempted with one is refused and raises a sticky error flag.

Top module: `spi_baud_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk_o`, `launch_o`, `capture_o` and `err_o` are all 0.
- R2: While no transfer is running, `sclk_o` is 0 and neither strobe fires.
- R3: Let the effective divisor be d. A serial clock period lasts d source ticks. The low phase lasts ceil(d/2) ticks and the high phase lasts floor(d/2) ticks, so an odd divisor gives a high phase one tick shorter than the low phase.
- R4: A divisor of 1 behaves exactly like a divisor of 2, so the period is never shorter than two system clock cycles.
- R5: With `src_div32_i` = 0, one source tick is one system clock cycle. With `src_div32_i` = 1, one source tick is 32 system clock cycles.
- R6: The divisor for select k sits in `div_i[8k+7:8k]`. The transfer uses the divisor of the select given on `cs_sel_i` when it starts.
- R7: Changes to `cs_sel_i`, `div_i` or `src_div32_i` during a running transfer do not change that transfer's clock.
- R8: A start attempt (no transfer running and `run_i` = 1) with a selected divisor of 0 is refused: no transfer starts, `sclk_o` stays 0, and `err_o` reads 1 from the next cycle.
- R9: `err_o` stays at 1 until a cycle with `err_clr_i` = 1 clears it. If a refused start happens in the same cycle as the clear, the flag stays set.
- R10: `capture_o` is 1 for exactly the cycle in which `sclk_o` first reads 1 after a low phase. `launch_o` is 1 for exactly the cycle in which `sclk_o` first reads 0 after a high phase inside a running transfer. Dropping `run_i` returns `sclk_o` to 0 on the next edge without a launch strobe.
- R11: Every start clears the prescaler and phase counters. The first rising edge appears ceil(d/2) source ticks after the start cycle, even if the previous transfer stopped part way through a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_div32_i | input | 1 | Source select: 0 = system clock, 1 = system clock / 32 |
| div_i | input | 32 | Four packed 8-bit divisors; select k in bits [8k+7:8k] |
| cs_sel_i | input | 2 | Index of the addressed peripheral select |
| run_i | input | 1 | High while a transfer should run |
| err_clr_i | input | 1 | Clears the sticky error flag |
| sclk_o | output | 1 | Serial clock, idle low |
| launch_o | output | 1 | One-cycle strobe on each falling serial clock edge |
| capture_o | output | 1 | One-cycle strobe on each rising serial clock edge |
| err_o | output | 1 | Sticky flag for a refused zero-divisor start |

## Verification
The assertions assume that `run_i` is the only thing that ends a transfer. They also assume the error flag changes only through a refused start or `err_clr_i`. The stimulus therefore drives every input at the falling clock edge and never leaves these two paths. The assertions further rely on the internal running state being the sole gate on the serial clock, and the stimulus tries to break that. It stops transfers during the high phase and restarts them in the very next cycle. It also rewrites divisors, select and source while a transfer runs, and pulses the clear in the same cycle as a refused start. All of this stays inside the input contract.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  typedef enum logic {
    SRC_SYS = 1'b0,
    SRC_PRE = 1'b1
  } src_sel_e;

  localparam int unsigned MIN_DIV = 2;
endpackage

// File: rtl/spi_baud_presc.sv
module spi_baud_presc #(
  parameter int unsigned PRESC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bypass_i,
  output logic tick_o
);
  generate
    if (PRESC > 1) begin : g_cnt
      localparam int unsigned PRE_W = $clog2(PRESC);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESC - 1);
      logic [PRE_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 cnt_q <= '0;
        else if (clr_i)              cnt_q <= '0;
        else if (en_i && !bypass_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + PRE_W'(1);
      end

      assign tick_o = en_i && (bypass_i || cnt_q == LAST);
    end else begin : g_none
      assign tick_o = en_i;
    end
  endgenerate
endmodule

// File: rtl/spi_baud_phase.sv
module spi_baud_phase #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] lo_len_i,
  input  logic [DIV_W-1:0] hi_len_i,
  output logic             sclk_o,
  output logic             capture_o,
  output logic             launch_o
);
  logic [DIV_W-1:0] ph_q;
  logic             sclk_q, cap_q, lau_q;
  logic [DIV_W-1:0] ph_last;

  assign ph_last = (sclk_q ? hi_len_i : lo_len_i) - DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
      cap_q  <= 1'b0;
      lau_q  <= 1'b0;
    end else if (clr_i) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
      cap_q  <= 1'b0;
      lau_q  <= 1'b0;
    end else begin
      cap_q <= 1'b0;
      lau_q <= 1'b0;
      if (tick_i) begin
        if (ph_q == ph_last) begin
          ph_q   <= '0;
          sclk_q <= !sclk_q;
          cap_q  <= !sclk_q;
          lau_q  <= sclk_q;
        end else begin
          ph_q <= ph_q + DIV_W'(1);
        end
      end
    end
  end

  assign sclk_o    = sclk_q;
  assign capture_o = cap_q;
  assign launch_o  = lau_q;
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned PRESC  = 32,
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    src_div32_i,
  input  logic [NUM_CS*DIV_W-1:0] div_i,
  input  logic [SEL_W-1:0]        cs_sel_i,
  input  logic                    run_i,
  input  logic                    err_clr_i,
  output logic                    sclk_o,
  output logic                    launch_o,
  output logic                    capture_o,
  output logic                    err_o
);
  logic [DIV_W-1:0] div_arr [NUM_CS];

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
      assign div_arr[g] = div_i[g*DIV_W +: DIV_W];
    end
  endgenerate

  logic [DIV_W-1:0] sel_div;
  logic             sel_zero;
  logic             running_q, err_q;
  logic [DIV_W-1:0] lat_div_q;
  src_sel_e         lat_src_q;
  logic             start, err_set, cnt_clr, tick;
  logic [DIV_W-1:0] lo_len, hi_len;

  assign sel_div  = div_arr[cs_sel_i];
  assign sel_zero = (sel_div == '0);
  assign start    = !running_q && run_i && !sel_zero;
  assign err_set  = !running_q && run_i && sel_zero;
  // counters held clear whenever the transfer is idle or ending
  assign cnt_clr  = !(running_q && run_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      lat_div_q <= DIV_W'(MIN_DIV);
      lat_src_q <= SRC_SYS;
    end else if (start) begin
      running_q <= 1'b1;
      lat_div_q <= (sel_div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : sel_div;
      lat_src_q <= src_sel_e'(src_div32_i);
    end else if (!run_i) begin
      running_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (err_set)   err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign hi_len = lat_div_q >> 1;
  assign lo_len = hi_len + DIV_W'(lat_div_q[0]);

  spi_baud_presc #(.PRESC(PRESC)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .en_i     (!cnt_clr),
    .bypass_i (lat_src_q == SRC_SYS),
    .tick_o   (tick)
  );

  spi_baud_phase #(.DIV_W(DIV_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cnt_clr),
    .tick_i    (tick),
    .lo_len_i  (lo_len),
    .hi_len_i  (hi_len),
    .sclk_o    (sclk_o),
    .capture_o (capture_o),
    .launch_o  (launch_o)
  );

  assign err_o = err_q;
endmodule

// File: rtl/spi_baud_gen_chk.sv
module spi_baud_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic err_clr_i,
  input logic running_i,
  input logic sel_zero_i,
  input logic sclk_o,
  input logic launch_o,
  input logic capture_o,
  input logic err_o
);
  // R2
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |-> (!sclk_o && !capture_o && !launch_o));

  // R10
  capture_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> (sclk_o && !$past(sclk_o)));

  // R10
  launch_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (!sclk_o && $past(sclk_o)));

  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_o && launch_o));

  // R8
  zero_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_i && run_i && sel_zero_i) |=> (!running_i && err_o));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_o) && !$past(err_clr_i)) |-> err_o);

  // R10
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && !run_i) |=> (!sclk_o && !launch_o));
endmodule

bind spi_baud_gen spi_baud_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .err_clr_i  (err_clr_i),
  .running_i  (running_q),
  .sel_zero_i (sel_zero),
  .sclk_o     (sclk_o),
  .launch_o   (launch_o),
  .capture_o  (capture_o),
  .err_o      (err_o)
);

// File: tb/spi_baud_gen_test.sv
`timescale 1ns/1ps
module spi_baud_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src32 = 1'b0;
  logic [31:0] div = '0;
  logic [1:0]  sel = '0;
  logic        run = 1'b0;
  logic        eclr = 1'b0;
  logic        sclk, lau, cap, err;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R2";

  always #2 clk = ~clk;

  spi_baud_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .src_div32_i(src32), .div_i(div),
    .cs_sel_i(sel), .run_i(run), .err_clr_i(eclr),
    .sclk_o(sclk), .launch_o(lau), .capture_o(cap), .err_o(err)
  );

  // behavioural reference: elapsed cycles since start
  bit m_run = 0, m_err = 0;
  int m_t = 0, m_d = 2, m_u = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_err <= 0; m_t <= 0;
    end else begin
      int sd;
      bit set;
      sd  = (div >> (8 * sel)) & 8'hFF;
      set = !m_run && run && sd == 0;
      if (!m_run) begin
        if (run && sd != 0) begin
          m_run <= 1; m_t <= 0;
          m_d <= (sd < 2) ? 2 : sd;
          m_u <= src32 ? 32 : 1;
        end
      end else if (run) m_t <= m_t + 1;
      else m_run <= 0;
      if (set) m_err <= 1;
      else if (eclr) m_err <= 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int pos, lo;
      bit es, ec, el;
      es = 0; ec = 0; el = 0;
      if (m_run) begin
        lo  = (m_d + 1) / 2;
        pos = m_t % (m_d * m_u);
        es  = pos >= lo * m_u;
        ec  = pos == lo * m_u;
        el  = pos == 0 && m_t > 0;
      end
      chk(cur_req, "sclk", sclk, es);
      chk(cur_req == "R2" ? "R10" : cur_req, "capture", cap, ec);
      chk(cur_req == "R2" ? "R10" : cur_req, "launch", lau, el);
      chk(cur_req == "R8" ? "R8" : "R9", "err", err, m_err);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(int cs, bit s32, int n);
    sel = 2'(cs); src32 = s32; run = 1; step(n);
    run = 0; step(3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1
    chk("R1", "sclk", sclk, 0); chk("R1", "capture", cap, 0);
    chk("R1", "launch", lau, 0); chk("R1", "err", err, 0);
    rst_n = 1;
    step(1);
    chk("R1", "sclk_after", sclk, 0); chk("R1", "err_after", err, 0);

    cur_req = "R2"; step(5);

    // R8: divisors still zero after reset
    cur_req = "R8"; sel = 2; run = 1; step(6);
    run = 0; step(2);
    chk("R8", "err_set", err, 1);
    // R9: sticky then cleared
    cur_req = "R9"; step(4);
    chk("R9", "err_hold", err, 1);
    eclr = 1; step(1); eclr = 0; step(1);
    chk("R9", "err_clr", err, 0);
    // R9: set and clear in the same cycle, set wins
    run = 1; eclr = 1; step(1); run = 0; eclr = 0; step(1);
    chk("R9", "set_wins", err, 1);
    eclr = 1; step(1); eclr = 0; step(1);

    div = {8'd255, 8'd1, 8'd5, 8'd4};
    cur_req = "R3";  go(0, 0, 30);
    cur_req = "R3";  go(1, 0, 33);
    cur_req = "R4";  go(2, 0, 20);
    cur_req = "R6";  go(3, 0, 600);
    cur_req = "R5";  go(1, 1, 700);
    cur_req = "R10"; go(0, 0, 15);

    // R7: rewrite everything mid-transfer
    cur_req = "R7"; sel = 1; src32 = 0; run = 1; step(7);
    sel = 0; src32 = 1; div = {8'd9, 8'd9, 8'd9, 8'd9}; step(25);
    run = 0; step(3);

    // R11: stop mid-period, restart next cycle
    div = {8'd255, 8'd1, 8'd5, 8'd3};
    cur_req = "R11"; sel = 0; src32 = 1; run = 1; step(77);
    run = 0; step(1); run = 1; step(250);
    run = 0; step(1); src32 = 0; run = 1; step(4);
    run = 0; step(1); run = 1; step(12);
    run = 0; step(3);

    // R5 slowest rate, one full period
    cur_req = "R5"; go(3, 1, 8300);

    // R8: zero divisor on one select only; R6 others unaffected
    div = {8'd6, 8'd0, 8'd5, 8'd4};
    cur_req = "R8"; go(2, 0, 10);
    chk("R8", "err_zero_sel", err, 1);
    eclr = 1; step(1); eclr = 0;
    cur_req = "R6"; go(3, 0, 20);
    cur_req = "R2"; step(5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule